// File: doc/BRIEF.md
# Pitch-Blended Wavetable Oscillator

This oscillator produces one audio sample per sample tick (nominally 48 kHz) from a bank of single-cycle waveforms. Each waveform holds one period and belongs to its own reference pitch, and several reference pitches fall within each octave. A 32-bit phase accumulator moves forward by a programmable increment on every tick. Its top bits pick the position inside the period.

The requested pitch is a logarithmic code. Its upper part names the nearest reference table at or below the pitch, and its lower 8 bits give how far the pitch has moved toward the next table up. Both tables are read at the same phase in the same cycle, and the two values are crossfaded with a rounded linear blend. A pitch below the first reference plays the first table alone. A pitch at or beyond the last reference plays the last table alone. Software or a loader fills the tables beforehand through a plain write port.

Top module: `wavetable_osc`

## Requirements
- R1: While `rst_n` is low, `sample_out` is 0 and `out_valid` is 0. The phase accumulator restarts at 0, so the first tick after reset reads table position 0.
- R2: On each tick the table position used is bits [31:24] of the accumulator value held before that tick. The accumulator then becomes that value plus `freq_inc`, modulo 2^32.
- R3: `out_valid` is high for exactly one cycle, two clock cycles after the cycle in which `tick` is high. `sample_out` changes only in that cycle and otherwise holds its value.
- R4: For a pitch code p with 256 <= p < 2048, the lower table is (p-256)>>8, the upper table is the lower table plus 1, and the weight w is (p-256) mod 256.
- R5: The output is a + floor((w*(b-a) + 128) / 256). Here a and b are the lower and upper table entries, taken as signed 16-bit two's-complement values.
- R6: A pitch code below 256 gives entry a of table 0 unblended (w = 0).
- R7: A pitch code of 2048 or more gives entry a of table 7 unblended (w = 0).
- R8: A write with `wr_en` high stores `wr_data` at position `wr_addr` of table `wr_table`. Every tick issued in a later cycle reads the new value.
- R9: `pitch` and `freq_inc` are sampled only in a tick cycle. Changes to them between ticks leave the output, the valid flag and the accumulator untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample tick, one cycle wide |
| freq_inc | input | 32 | Phase increment per tick |
| pitch | input | 12 | Log-pitch code (reference step 256, first reference at 256) |
| wr_en | input | 1 | Table write strobe |
| wr_table | input | 3 | Table number for the write |
| wr_addr | input | 8 | Position within the table for the write |
| wr_data | input | 16 | Signed sample to store |
| sample_out | output | 16 | Signed blended sample |
| out_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The tables are filled with values that depend on both the table number and the position, so every wrong choice shows up as a wrong value at `sample_out` on the very next sample. A wrong choice here means a stale or mis-stepped accumulator, a wrong table pair, or a misplaced weight. A sign or rounding slip in the blend shows up only when the upper entry is below the lower entry, or when the fraction sits near one half, so those cases are driven on purpose. A pipeline register that fires on the wrong cycle moves the `out_valid` strobe off the second cycle after the tick, and the bench sees this at once.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int SAMP_W     = 16;
  localparam int ADDR_W     = 8;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PHASE_W    = 32;
  localparam int NUM_TABLES = 8;
  localparam int TSEL_W     = $clog2(NUM_TABLES);
  localparam int WGT_W      = 8;
  localparam int PITCH_W    = 12;
  localparam int PITCH_BASE = 256;
  localparam int TOP_SPAN   = (NUM_TABLES - 1) << WGT_W;
  localparam int MEM_WORDS  = NUM_TABLES * DEPTH;
  localparam int ROUND_HALF = 1 << (WGT_W - 1);
  localparam int BLEND_W    = SAMP_W + WGT_W + 2;

  typedef struct packed {
    logic [TSEL_W-1:0] lo;
    logic [TSEL_W-1:0] hi;
    logic [WGT_W-1:0]  w;
  } sel_t;

  // Pitch code -> table pair and crossfade weight, clamped at both edges.
  function automatic sel_t decode(input logic [PITCH_W-1:0] p);
    sel_t s;
    logic [PITCH_W-1:0] rel;
    s   = '0;
    rel = p - PITCH_W'(PITCH_BASE);
    if (p < PITCH_W'(PITCH_BASE)) begin
      s.lo = '0;
      s.hi = '0;
    end else if (rel >= PITCH_W'(TOP_SPAN)) begin
      s.lo = TSEL_W'(NUM_TABLES - 1);
      s.hi = TSEL_W'(NUM_TABLES - 1);
    end else begin
      s.lo = TSEL_W'(rel >> WGT_W);
      s.hi = s.lo + TSEL_W'(1);
      s.w  = rel[WGT_W-1:0];
    end
    return s;
  endfunction

  // Rounded crossfade a + w*(b-a)/2^WGT_W with arithmetic (floor) shift.
  function automatic logic [SAMP_W-1:0] blend(input logic [SAMP_W-1:0] a,
                                              input logic [SAMP_W-1:0] b,
                                              input logic [WGT_W-1:0]  w);
    logic signed [BLEND_W-1:0] ae, be, we, prod;
    ae   = BLEND_W'($signed(a));
    be   = BLEND_W'($signed(b));
    we   = BLEND_W'({1'b0, w});
    prod = (be - ae) * we + BLEND_W'(ROUND_HALF);
    return SAMP_W'(ae + (prod >>> WGT_W));
  endfunction
endpackage

// File: rtl/wt_phase.sv
module wt_phase
  import wt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PHASE_W-1:0] freq_inc,
  output logic [ADDR_W-1:0]  rd_addr
);
  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= phase + freq_inc;
  end

  assign rd_addr = phase[PHASE_W-1 -: ADDR_W];

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase == $past(phase) + $past(freq_inc)); // R2
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase)); // R9
endmodule

// File: rtl/wt_select.sv
module wt_select
  import wt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PITCH_W-1:0] pitch,
  output logic [TSEL_W-1:0]  sel_lo,
  output logic [TSEL_W-1:0]  sel_hi,
  output logic [WGT_W-1:0]   wgt_q
);
  sel_t cur;

  always_comb cur = decode(pitch);
  assign sel_lo = cur.lo;
  assign sel_hi = cur.hi;

  // Weight travels alongside the synchronous table reads.
  always_ff @(posedge clk) begin
    if (!rst_n)    wgt_q <= '0;
    else if (tick) wgt_q <= cur.w;
  end

  AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi == sel_lo) || (sel_hi == sel_lo + TSEL_W'(1))); // R4
  AST_EDGE_ONLY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi == sel_lo) |-> (sel_lo == '0 || sel_lo == TSEL_W'(NUM_TABLES - 1))); // R7
  AST_EDGE_NO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel_hi == sel_lo) |=> wgt_q == '0); // R6
endmodule

// File: rtl/wt_store.sv
module wt_store
  import wt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TSEL_W-1:0] wr_table,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SAMP_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TSEL_W-1:0] rd_lo,
  input  logic [TSEL_W-1:0] rd_hi,
  output logic [SAMP_W-1:0] rd_a,
  output logic [SAMP_W-1:0] rd_b,
  output logic              rd_valid
);
  logic [SAMP_W-1:0] mem [MEM_WORDS];
  logic [TSEL_W-1:0] port_tbl [2];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_table, wr_addr}] <= wr_data;
  end

  assign port_tbl[0] = rd_lo;
  assign port_tbl[1] = rd_hi;

  for (genvar g = 0; g < 2; g++) begin : g_rd
    logic [SAMP_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rd_en) q <= mem[{port_tbl[g], rd_addr}];
    end
  end

  assign rd_a = g_rd[0].q;
  assign rd_b = g_rd[1].q;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  AST_READ_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R3
  AST_NO_STRAY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R3
endmodule

// File: rtl/wt_mix.sv
module wt_mix
  import wt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [SAMP_W-1:0] rd_a,
  input  logic [SAMP_W-1:0] rd_b,
  input  logic [WGT_W-1:0]  wgt,
  output logic [SAMP_W-1:0] sample_out,
  output logic              out_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_out <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= rd_valid;
      if (rd_valid) sample_out <= blend(rd_a, rd_b, wgt);
    end
  end

  AST_BLEND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (($signed(sample_out) >= $signed($past(rd_a)) &&
                   $signed(sample_out) <= $signed($past(rd_b))) ||
                  ($signed(sample_out) <= $signed($past(rd_a)) &&
                   $signed(sample_out) >= $signed($past(rd_b))))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(sample_out)); // R3
endmodule

// File: rtl/wavetable_osc.sv
module wavetable_osc
  import wt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PHASE_W-1:0] freq_inc,
  input  logic [PITCH_W-1:0] pitch,
  input  logic               wr_en,
  input  logic [TSEL_W-1:0]  wr_table,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [SAMP_W-1:0]  wr_data,
  output logic [SAMP_W-1:0]  sample_out,
  output logic               out_valid
);
  logic [ADDR_W-1:0] rd_addr;
  logic [TSEL_W-1:0] sel_lo, sel_hi;
  logic [WGT_W-1:0]  wgt_q;
  logic [SAMP_W-1:0] rd_a, rd_b;
  logic              rd_valid;

  wt_phase u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freq_inc(freq_inc), .rd_addr(rd_addr)
  );

  wt_select u_select (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pitch(pitch),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .wgt_q(wgt_q)
  );

  wt_store u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_table(wr_table), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(tick), .rd_addr(rd_addr), .rd_lo(sel_lo), .rd_hi(sel_hi),
    .rd_a(rd_a), .rd_b(rd_b), .rd_valid(rd_valid)
  );

  wt_mix u_mix (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_a(rd_a), .rd_b(rd_b),
    .wgt(wgt_q), .sample_out(sample_out), .out_valid(out_valid)
  );

  AST_TICK_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ##2 out_valid); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (sample_out == '0 && !out_valid)); // R1
endmodule

// File: tb/wavetable_osc_test.sv
`timescale 1ns/100ps
module wavetable_osc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] freq_inc = '0;
  logic [11:0] pitch = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_table = '0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] sample_out;
  logic        out_valid;

  int n_chk = 0;
  int n_bad = 0;
  int model_mem [8][256];
  logic [31:0] model_phase = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wavetable_osc uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freq_inc(freq_inc), .pitch(pitch),
    .wr_en(wr_en), .wr_table(wr_table), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_out(sample_out), .out_valid(out_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tv(input int t, input int i);
    return (i - 128) * (t + 1) * 20 + t * 7;
  endfunction

  // Bench-side expected sample: table choice, then floor-rounded crossfade.
  function automatic int expect_sample(input logic [11:0] p, input int pos);
    int lo, hi, w, r, num, md;
    if (p < 12'd256) begin lo = 0; hi = 0; w = 0; end
    else begin
      r = int'(p) - 256;
      if (r >= 1792) begin lo = 7; hi = 7; w = 0; end
      else begin lo = r / 256; hi = lo + 1; w = r % 256; end
    end
    num = w * (model_mem[hi][pos] - model_mem[lo][pos]) + 128;
    md  = ((num % 256) + 256) % 256;
    return model_mem[lo][pos] + (num - md) / 256;
  endfunction

  task automatic write_entry(input int t, input int i, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_table = 3'(t); wr_addr = 8'(i); wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
    model_mem[t][i] = v;
  endtask

  // One tick; checks strobe timing, value, and hold afterwards.
  task automatic fire(input string req, input logic [11:0] p, input logic [31:0] inc);
    int exp, held;
    exp = expect_sample(p, int'(model_phase[31:24]));
    model_phase = model_phase + inc;
    @(negedge clk);
    pitch = p; freq_inc = inc; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    held = int'($signed(sample_out));
    chk("R3 valid low one cycle after tick", int'(out_valid), 0);
    @(negedge clk);
    chk("R3 valid two cycles after tick", int'(out_valid), 1);
    chk(req, int'($signed(sample_out)), exp);
    held = int'($signed(sample_out));
    @(negedge clk);
    chk("R3 valid single cycle", int'(out_valid), 0);
    chk("R3 output held", int'($signed(sample_out)), held);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sample zero in reset", int'(sample_out), 0);
    chk("R1 valid low in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    model_phase = '0;
  endtask

  task automatic t_load;
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 256; i++)
        write_entry(t, i, tv(t, i));
  endtask

  task automatic t_first_and_phase;
    fire("R1 first tick reads position 0", 12'd256, 32'h0100_0000);
    fire("R2 step by one position", 12'd256, 32'h0350_0000);
    fire("R2 fractional increment", 12'd300, 32'h00C0_0000);
    fire("R2 accumulator wrap", 12'd512, 32'hF000_0000);
    fire("R2 wrap again", 12'd700, 32'hFFFF_FFFF);
  endtask

  task automatic t_blend;
    fire("R4 R5 mid weight", 12'd384, 32'h1234_5678);
    fire("R4 R5 weight 255", 12'd511, 32'h0F00_0000);
    fire("R4 R5 weight 1", 12'd1025, 32'h2100_0000);
    fire("R4 R5 upper pair", 12'd2047, 32'h0080_0000);
    fire("R4 R5 weight zero on reference", 12'd768, 32'h6000_0000);
  endtask

  task automatic t_edges;
    fire("R6 below lowest", 12'd0, 32'h0500_0000);
    fire("R6 just below lowest", 12'd255, 32'h4400_0000);
    fire("R7 exactly at top reference", 12'd2048, 32'h0300_0000);
    fire("R7 far above top", 12'd4095, 32'h7700_0000);
  endtask

  task automatic t_write;
    int pos;
    pos = int'(model_phase[31:24]);
    write_entry(2, pos, -30000);
    write_entry(3, pos, 29000);
    fire("R8 rewritten entries used", 12'd896, 32'h0100_0000);
  endtask

  task automatic t_idle_inputs;
    int held;
    held = int'($signed(sample_out));
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      pitch = 12'(k * 613); freq_inc = 32'(k) * 32'h1357_9BDF;
      chk("R9 no strobe between ticks", int'(out_valid), 0);
      chk("R9 output unchanged between ticks", int'($signed(sample_out)), held);
    end
    fire("R9 accumulator untouched by idle changes", 12'd1500, 32'h0200_0000);
  endtask

  initial begin
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < 256; i++)
        model_mem[t][i] = 0;
    t_reset();
    t_load();
    t_first_and_phase();
    t_blend();
    t_edges();
    t_write();
    t_idle_inputs();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule